// File: doc/BRIEF.md
# Counter Enable Set Register

This block stores the run/stop enable bits for a bank of performance counters: one cycle counter and up to 31 event counters. Software turns counters on through a set port, where every 1 in the write data enables the matching counter and every 0 leaves it alone. A companion clear port shares the same storage and turns counters off the same way. The read value and the per-counter enable lines both show the stored bits.

Not every event counter is visible to every caller. An effective counter count N is chosen on each access. When the hypervisor level is enabled and the access comes from one of the two lowest privilege levels, N is the hypervisor's counter limit. Otherwise N is the implemented-counter count. Event bits at or above N read as zero, never drive an enable line, and are not changed by either port. The cycle-counter bit is never hidden. N is combinational on the privilege inputs, so the same stored state can read differently at different privilege levels.

There is no sequencing in this block. The only state is the enable vector, so nothing here waits on or orders a transaction. The privilege decode is a named enumeration: user, kernel, hypervisor and monitor.

Top module: `cnt_enable_bank`

## Requirements
- R1: While `rst_n` is low, the stored bits clear to zero, so after reset `rd_data` reads 0.
- R2: A set write turns on every visible bit whose data bit is 1. Data bits that are 0 leave the stored bit unchanged. The result is visible on `rd_data` after the clock edge that takes the write.
- R3: A clear write turns off every visible bit whose data bit is 1. Data bits that are 0 leave the stored bit unchanged.
- R4: If set and clear both target the same bit in the same cycle, that bit ends up enabled.
- R5: N is `hyp_limit` when `hyp_en` is 1 and `priv_lvl` is 0 (user) or 1 (kernel). For every other combination, N is `impl_count`.
- R6: Event bits at index N or above read as 0. Set and clear writes to those bits are ignored: raising N later shows the bits as they were before the write.
- R7: Bit 31 (the cycle counter) is visible and writable for every value of N.
- R8: `cyc_en` equals `rd_data[31]`, and `evt_en[i]` equals `rd_data[i]`. A hidden counter is never enabled.
- R9: A limit value above 31 is treated as 31, so all event bits are visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_we | input | 1 | Set-port write strobe |
| set_data | input | 32 | Set-port data: each 1 enables the matching counter |
| clr_we | input | 1 | Clear-port write strobe |
| clr_data | input | 32 | Clear-port data: each 1 disables the matching counter |
| priv_lvl | input | 2 | Privilege level of the access: 0 user, 1 kernel, 2 hypervisor, 3 monitor |
| hyp_en | input | 1 | Hypervisor level is implemented and enabled |
| hyp_limit | input | 6 | Hypervisor counter limit |
| impl_count | input | 6 | Number of implemented event counters |
| rd_data | output | 32 | Visible enable bits |
| cyc_en | output | 1 | Cycle-counter enable |
| evt_en | output | 31 | Event-counter enables |

## Verification
The set port and the clear port can both write in the same cycle, and they can target the same bit. The bench drives both strobes together with overlapping data patterns. It covers every privilege level, both `hyp_en` settings, and a spread of limit values. For each case it computes the expected vector arithmetically, letting set win on shared bits and leaving hidden bits untouched. A second kind of overlap comes from a privilege change between writes: a hidden bit must stay as it was. The bench checks this by raising N afterwards and reading the bit back.

// File: rtl/cnt_enable_pkg.sv
package cnt_enable_pkg;

    typedef enum logic [1:0] {
        PL_USER = 2'd0,
        PL_KERN = 2'd1,
        PL_HYP  = 2'd2,
        PL_MON  = 2'd3
    } priv_e;

endpackage

// File: rtl/cnt_limit_sel.sv
module cnt_limit_sel
    import cnt_enable_pkg::*;
#(
    parameter int NUM_EVT = 31,
    parameter int LIMIT_W = 6,
    localparam int CNT_W  = $clog2(NUM_EVT + 1)
) (
    input  priv_e              priv_lvl,
    input  logic               hyp_en,
    input  logic [LIMIT_W-1:0] hyp_limit,
    input  logic [LIMIT_W-1:0] impl_count,
    output logic [CNT_W-1:0]   n_eff
);

    logic               use_hyp;
    logic [LIMIT_W-1:0] raw;

    // The two lowest levels see the hypervisor's limit when it is active.
    always_comb begin
        unique case (priv_lvl)
            PL_USER, PL_KERN: use_hyp = hyp_en;
            PL_HYP, PL_MON:   use_hyp = 1'b0;
            default:          use_hyp = 1'b0;
        endcase
    end

    assign raw   = use_hyp ? hyp_limit : impl_count;
    // A limit above the bank size means every event counter is visible.
    assign n_eff = (raw > LIMIT_W'(NUM_EVT)) ? CNT_W'(NUM_EVT) : CNT_W'(raw);

endmodule

// File: rtl/cnt_mask_gen.sv
module cnt_mask_gen #(
    parameter int NUM_EVT = 31,
    localparam int CNT_W  = $clog2(NUM_EVT + 1),
    localparam int REG_W  = NUM_EVT + 1
) (
    input  logic [CNT_W-1:0] n_eff,
    output logic [REG_W-1:0] vis_mask
);

    // Thermometer code: event bit i is visible when i < N.
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        assign vis_mask[i] = (n_eff > CNT_W'(i));
    end

    // The cycle-counter bit is never hidden.
    assign vis_mask[NUM_EVT] = 1'b1;

endmodule

// File: rtl/cnt_en_store.sv
module cnt_en_store #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic [REG_W-1:0] set_m,
    input  logic             clr_we,
    input  logic [REG_W-1:0] clr_m,
    input  logic [REG_W-1:0] vis_mask,
    output logic [REG_W-1:0] en_q
);

    logic [REG_W-1:0] set_v;
    logic [REG_W-1:0] clr_v;
    logic [REG_W-1:0] en_d;

    assign set_v = set_we ? set_m : '0;
    assign clr_v = clr_we ? clr_m : '0;
    // Set is applied after clear, so set wins on a shared bit.
    assign en_d  = (en_q & ~clr_v) | set_v;

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> en_q == '0);

    a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> (en_q & $past(set_m)) == $past(set_m));

    a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> (en_q & $past(clr_m)) == '0);

    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && clr_we) |=> (en_q & $past(set_m & clr_m)) == $past(set_m & clr_m));

    a_r6_hidden_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (en_q & ~$past(vis_mask)) == ($past(en_q) & ~$past(vis_mask)));

endmodule

// File: rtl/cnt_enable_bank.sv
module cnt_enable_bank
    import cnt_enable_pkg::*;
#(
    parameter int NUM_EVT = 31,
    parameter int LIMIT_W = 6,
    localparam int REG_W  = NUM_EVT + 1,
    localparam int CNT_W  = $clog2(NUM_EVT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_we,
    input  logic [REG_W-1:0]   set_data,
    input  logic               clr_we,
    input  logic [REG_W-1:0]   clr_data,
    input  logic [1:0]         priv_lvl,
    input  logic               hyp_en,
    input  logic [LIMIT_W-1:0] hyp_limit,
    input  logic [LIMIT_W-1:0] impl_count,
    output logic [REG_W-1:0]   rd_data,
    output logic               cyc_en,
    output logic [NUM_EVT-1:0] evt_en
);

    priv_e            pl;
    logic [CNT_W-1:0] n_eff;
    logic [REG_W-1:0] vis_mask;
    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] vis_en;

    assign pl = priv_e'(priv_lvl);

    cnt_limit_sel #(.NUM_EVT(NUM_EVT), .LIMIT_W(LIMIT_W)) u_lim (
        .priv_lvl   (pl),
        .hyp_en     (hyp_en),
        .hyp_limit  (hyp_limit),
        .impl_count (impl_count),
        .n_eff      (n_eff)
    );

    cnt_mask_gen #(.NUM_EVT(NUM_EVT)) u_mask (
        .n_eff    (n_eff),
        .vis_mask (vis_mask)
    );

    // Writes to hidden bits are dropped before they reach storage.
    cnt_en_store #(.REG_W(REG_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (set_we),
        .set_m    (set_data & vis_mask),
        .clr_we   (clr_we),
        .clr_m    (clr_data & vis_mask),
        .vis_mask (vis_mask),
        .en_q     (en_q)
    );

    assign vis_en  = en_q & vis_mask;
    assign rd_data = vis_en;
    assign cyc_en  = vis_en[NUM_EVT];
    assign evt_en  = vis_en[NUM_EVT-1:0];

    a_r5_mask_width: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vis_mask[NUM_EVT-1:0]) == int'(n_eff));

    a_r8_no_hidden_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_en & ~vis_mask[NUM_EVT-1:0]) == '0);

    a_r7_cycle_follows_store: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_en == en_q[NUM_EVT]);

endmodule

// File: tb/cnt_enable_bank_bench.sv
module cnt_enable_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_we = 1'b0;
    logic [31:0] set_data = '0;
    logic        clr_we = 1'b0;
    logic [31:0] clr_data = '0;
    logic [1:0]  priv_lvl = 2'd3;
    logic        hyp_en = 1'b0;
    logic [5:0]  hyp_limit = 6'd31;
    logic [5:0]  impl_count = 6'd31;
    logic [31:0] rd_data;
    logic        cyc_en;
    logic [30:0] evt_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [31:0] mdl = '0;

    always #5 clk = ~clk;

    cnt_enable_bank u_cnt_enable_bank (
        .clk(clk), .rst_n(rst_n),
        .set_we(set_we), .set_data(set_data),
        .clr_we(clr_we), .clr_data(clr_data),
        .priv_lvl(priv_lvl), .hyp_en(hyp_en),
        .hyp_limit(hyp_limit), .impl_count(impl_count),
        .rd_data(rd_data), .cyc_en(cyc_en), .evt_en(evt_en)
    );

    function automatic int eff_n();
        int n;
        n = (hyp_en && priv_lvl < 2) ? int'(hyp_limit) : int'(impl_count);
        return (n > 31) ? 31 : n;
    endfunction

    function automatic logic [31:0] emask();
        return 32'h8000_0000 | ((32'h1 << eff_n()) - 32'h1);
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, rd_data, mdl & emask());
        chk({req, " R8"}, {cyc_en, evt_en}, rd_data);
    endtask

    // Drive one cycle of port traffic; the model follows the requirement text.
    task automatic op(input logic sw, input logic [31:0] sd, input logic cw, input logic [31:0] cd);
        logic [31:0] m;
        @(negedge clk);
        set_we = sw; set_data = sd; clr_we = cw; clr_data = cd;
        m = emask();
        if (cw) mdl = mdl & ~(cd & m);
        if (sw) mdl = mdl | (sd & m);
        @(negedge clk);
        set_we = 1'b0; clr_we = 1'b0;
    endtask

    task automatic cfg(input logic [1:0] p, input logic h, input logic [5:0] hl, input logic [5:0] ic);
        @(negedge clk);
        priv_lvl = p; hyp_en = h; hyp_limit = hl; impl_count = ic;
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] lcg;
        int nlist [8];
        nlist = '{0, 1, 5, 17, 30, 31, 40, 63};
        lcg = 32'h1234_5678;
        repeat (3) @(negedge clk);
        chk("R1 reset", rd_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", rd_data, 32'h0);

        // R2 R3 R4 R5 R7 sweep over privilege, hypervisor flag and limit.
        for (int p = 0; p < 4; p++) begin
            for (int h = 0; h < 2; h++) begin
                for (int k = 0; k < 8; k++) begin
                    cfg(2'(p), 1'(h), 6'(nlist[k]), 6'((nlist[k] * 3 + 11) % 64));
                    check_all("R5 R7 config");
                    lcg = lcg * 32'd1664525 + 32'd1013904223;
                    op(1'b1, lcg, 1'b0, 32'h0);
                    check_all("R2 set");
                    lcg = lcg * 32'd1664525 + 32'd1013904223;
                    op(1'b0, 32'h0, 1'b1, lcg);
                    check_all("R3 clear");
                    lcg = lcg * 32'd1664525 + 32'd1013904223;
                    op(1'b1, lcg, 1'b1, lcg ^ 32'h0F0F_F0F0);
                    check_all("R4 collision");
                    op(1'b1, 32'h8000_0000, 1'b0, 32'h0);
                    chk("R7 cycle bit", {31'h0, cyc_en}, 32'h1);
                end
            end
        end

        // R6 hidden bits ignore set and clear.
        cfg(2'd2, 1'b0, 6'd0, 6'd40);
        op(1'b0, 32'h0, 1'b1, 32'hFFFF_FFFF);
        chk("R6 cleared full", rd_data, 32'h0);
        cfg(2'd2, 1'b0, 6'd0, 6'd4);
        op(1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0);
        chk("R6 low N read", rd_data, 32'h8000_000F);
        cfg(2'd2, 1'b0, 6'd0, 6'd40);
        chk("R6 set ignored", rd_data, 32'h8000_000F);
        op(1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0);
        cfg(2'd2, 1'b0, 6'd0, 6'd4);
        op(1'b0, 32'h0, 1'b1, 32'hFFFF_FFFF);
        chk("R6 low N clear", rd_data, 32'h0);
        cfg(2'd2, 1'b0, 6'd0, 6'd40);
        chk("R6 clear ignored", rd_data, 32'h7FFF_FFF0);

        // R5 same state, different views by privilege.
        cfg(2'd0, 1'b1, 6'd8, 6'd40);
        chk("R5 user under hyp", rd_data, 32'h0000_00F0);
        cfg(2'd2, 1'b1, 6'd8, 6'd40);
        chk("R5 hyp level", rd_data, 32'h7FFF_FFF0);
        cfg(2'd1, 1'b0, 6'd8, 6'd16);
        chk("R5 kernel no hyp", rd_data, 32'h0000_FFF0);

        // R9 clamp of large limits.
        cfg(2'd3, 1'b0, 6'd0, 6'd63);
        chk("R9 clamp", rd_data, 32'h7FFF_FFF0);
        chk("R8 evt lines", {1'b0, evt_en}, 32'h7FFF_FFF0);

        // R1 reset mid-run.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 re-reset", rd_data, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule